// File: doc/BRIEF.md
# Address-Matched Write Poison Trigger

This block sits beside the system-side write path of a memory controller. It decides, for each accepted write, whether that write should be marked for error injection. Each transaction arrives with its address already split into DRAM coordinates: row, column, bank, bank group, rank, stacked logical rank and sub-channel. Every coordinate has its own compare value and its own ignore mask. When every compared bit agrees, the transaction qualifies.

A control word holds two bits. `en` turns the trigger on. `persist` selects the mode: when set, every qualifying write is marked; when clear, only the first qualifying write is marked, and the trigger then stays quiet until software writes the control word again. A sticky `oneshot_done` output lets software poll for completion of a single-shot injection.

The `poison` flag is combinational. It is only asserted in the cycle in which the write handshake completes. A transaction stalled over several cycles therefore yields at most one flag.

Top module: `wr_poison_trigger`

## Requirements
- R1: After reset, `poison` and `oneshot_done` are 0, all masks and compare values are 0, and the trigger is disabled.
- R2: A write qualifies only when, for every coordinate, each bit whose mask bit is 0 equals the corresponding compare bit. With all masks 0, the compare values row=2 and col=0x20 and all other coordinates 0, only that exact location is flagged.
- R3: A mask bit of 1 removes that address bit from the comparison.
- R4: While the control bit `en` (cfg address 15, bit 0) is 0, `poison` stays 0.
- R5: With `en`=1 and `persist` (cfg address 15, bit 1) = 1, every qualifying write is flagged.
- R6: With `en`=1 and `persist`=0, only the first qualifying accepted write after a control write is flagged. Later qualifying writes are not flagged.
- R7: A control write re-arms single-shot mode and clears `oneshot_done`.
- R8: `oneshot_done` becomes 1 in the cycle after a single-shot write is flagged.
- R9: `poison` is 1 only when `wr_valid` and `wr_ready` are both 1. A stalled write does not consume the single-shot arm.
- R10: A transaction with `wr_is_write`=0 is never flagged.
- R11: Config map (`cfg_addr`): 0..6 hold the masks for row, column, bank, bank group, rank, logical rank and sub-channel, in that order. 8..14 hold the compare values in the same order. 15 is the control word. Values occupy the low bits of `cfg_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 4 | Config register select |
| cfg_wdata | input | CFG_W | Config write data |
| wr_valid | input | 1 | Transaction valid |
| wr_ready | input | 1 | Transaction accepted by downstream |
| wr_is_write | input | 1 | Transaction carries system write data |
| wr_row | input | ROW_W | Row coordinate |
| wr_col | input | COL_W | Column coordinate |
| wr_bank | input | BANK_W | Bank coordinate |
| wr_bg | input | BG_W | Bank group coordinate |
| wr_rank | input | RANK_W | Rank coordinate |
| wr_lrank | input | LRANK_W | Stacked logical rank |
| wr_sub | input | SUB_W | Sub-channel |
| poison | output | 1 | Flag this accepted write for injection |
| oneshot_done | output | 1 | Single-shot injection has fired |

## Verification
The assertions assume that `wr_valid`, `wr_ready` and the configuration inputs are known after reset. They also assume that software does not reprogram the control word in the same cycle as a hit, except when it means to re-arm. The stimulus changes inputs only on falling edges. It holds all inputs idle between scenarios and issues each config write in a separate cycle from transaction traffic. It includes stalled and non-write transactions so that the single-shot arm and the handshake qualification are both exercised.

// File: rtl/wr_poison_trigger.sv
module wr_poison_trigger #(
  parameter int CFG_W   = 32,
  parameter int ROW_W   = 18,
  parameter int COL_W   = 10,
  parameter int BANK_W  = 2,
  parameter int BG_W    = 2,
  parameter int RANK_W  = 2,
  parameter int LRANK_W = 3,
  parameter int SUB_W   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [3:0]         cfg_addr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               wr_valid,
  input  logic               wr_ready,
  input  logic               wr_is_write,
  input  logic [ROW_W-1:0]   wr_row,
  input  logic [COL_W-1:0]   wr_col,
  input  logic [BANK_W-1:0]  wr_bank,
  input  logic [BG_W-1:0]    wr_bg,
  input  logic [RANK_W-1:0]  wr_rank,
  input  logic [LRANK_W-1:0] wr_lrank,
  input  logic [SUB_W-1:0]   wr_sub,
  output logic               poison,
  output logic               oneshot_done
);

  localparam logic [3:0] CTL_ADDR = 4'd15;

  logic [ROW_W-1:0]   msk_row,   cmp_row;
  logic [COL_W-1:0]   msk_col,   cmp_col;
  logic [BANK_W-1:0]  msk_bank,  cmp_bank;
  logic [BG_W-1:0]    msk_bg,    cmp_bg;
  logic [RANK_W-1:0]  msk_rank,  cmp_rank;
  logic [LRANK_W-1:0] msk_lrank, cmp_lrank;
  logic [SUB_W-1:0]   msk_sub,   cmp_sub;
  logic en_q, persist_q, armed_q, done_q;

  logic ctl_wr, addr_hit, take, fire;
  logic unused_cfg;

  assign unused_cfg = ^cfg_wdata;
  assign ctl_wr = cfg_we && (cfg_addr == CTL_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msk_row <= '0; msk_col <= '0; msk_bank <= '0; msk_bg <= '0;
      msk_rank <= '0; msk_lrank <= '0; msk_sub <= '0;
      cmp_row <= '0; cmp_col <= '0; cmp_bank <= '0; cmp_bg <= '0;
      cmp_rank <= '0; cmp_lrank <= '0; cmp_sub <= '0;
      en_q <= 1'b0;
      persist_q <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        4'd0:  msk_row   <= cfg_wdata[ROW_W-1:0];
        4'd1:  msk_col   <= cfg_wdata[COL_W-1:0];
        4'd2:  msk_bank  <= cfg_wdata[BANK_W-1:0];
        4'd3:  msk_bg    <= cfg_wdata[BG_W-1:0];
        4'd4:  msk_rank  <= cfg_wdata[RANK_W-1:0];
        4'd5:  msk_lrank <= cfg_wdata[LRANK_W-1:0];
        4'd6:  msk_sub   <= cfg_wdata[SUB_W-1:0];
        4'd8:  cmp_row   <= cfg_wdata[ROW_W-1:0];
        4'd9:  cmp_col   <= cfg_wdata[COL_W-1:0];
        4'd10: cmp_bank  <= cfg_wdata[BANK_W-1:0];
        4'd11: cmp_bg    <= cfg_wdata[BG_W-1:0];
        4'd12: cmp_rank  <= cfg_wdata[RANK_W-1:0];
        4'd13: cmp_lrank <= cfg_wdata[LRANK_W-1:0];
        4'd14: cmp_sub   <= cfg_wdata[SUB_W-1:0];
        4'd15: begin
          en_q      <= cfg_wdata[0];
          persist_q <= cfg_wdata[1];
        end
        default: ;
      endcase
    end
  end

  assign addr_hit =
      (((wr_row   ^ cmp_row)   & ~msk_row)   == '0) &&
      (((wr_col   ^ cmp_col)   & ~msk_col)   == '0) &&
      (((wr_bank  ^ cmp_bank)  & ~msk_bank)  == '0) &&
      (((wr_bg    ^ cmp_bg)    & ~msk_bg)    == '0) &&
      (((wr_rank  ^ cmp_rank)  & ~msk_rank)  == '0) &&
      (((wr_lrank ^ cmp_lrank) & ~msk_lrank) == '0) &&
      (((wr_sub   ^ cmp_sub)   & ~msk_sub)   == '0);

  assign take   = wr_valid && wr_ready && wr_is_write;
  assign fire   = take && en_q && addr_hit && (persist_q || armed_q);
  assign poison = fire;
  assign oneshot_done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (ctl_wr) begin
      armed_q <= 1'b1;
      done_q  <= 1'b0;
    end else if (fire && !persist_q) begin
      armed_q <= 1'b0;
      done_q  <= 1'b1;
    end
  end

  a_r9_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    poison |-> (wr_valid && wr_ready));
  a_r10_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    poison |-> wr_is_write);
  a_r6_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (poison && !persist_q && !ctl_wr) |=> !poison);
  a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (poison && !persist_q && !ctl_wr) |=> oneshot_done);
  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oneshot_done) |-> $past(poison));
  a_r7_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !oneshot_done);

endmodule

// File: tb/test_wr_poison_trigger.sv
module test_wr_poison_trigger;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic wr_valid = 0, wr_ready = 0, wr_is_write = 0;
  logic [17:0] wr_row = 0;
  logic [9:0]  wr_col = 0;
  logic [1:0]  wr_bank = 0, wr_bg = 0, wr_rank = 0;
  logic [2:0]  wr_lrank = 0;
  logic [0:0]  wr_sub = 0;
  logic poison, oneshot_done;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  wr_poison_trigger i_wr_poison_trigger (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_is_write(wr_is_write), .wr_row(wr_row), .wr_col(wr_col),
    .wr_bank(wr_bank), .wr_bg(wr_bg), .wr_rank(wr_rank),
    .wr_lrank(wr_lrank), .wr_sub(wr_sub), .poison(poison),
    .oneshot_done(oneshot_done));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic txn(input logic [17:0] row, input logic [9:0] col,
                     input logic [1:0] bank, input logic [0:0] sub,
                     input logic v, input logic r, input logic w,
                     output logic flag);
    @(negedge clk);
    wr_row = row; wr_col = col; wr_bank = bank; wr_bg = 0; wr_rank = 0;
    wr_lrank = 0; wr_sub = sub; wr_valid = v; wr_ready = r; wr_is_write = w;
    #1 flag = poison;
    @(negedge clk);
    wr_valid = 0; wr_ready = 0; wr_is_write = 0;
  endtask

  task automatic t_reset;
    logic f;
    chk("R1 poison after reset", poison, 1'b0);
    chk("R1 done after reset", oneshot_done, 1'b0);
    txn(0, 0, 0, 0, 1, 1, 1, f);
    chk("R1/R4 disabled by default", f, 1'b0);
  endtask

  task automatic t_exact;
    logic f;
    cfg(8, 2); cfg(9, 32'h20); cfg(15, 3);
    txn(2, 10'h20, 0, 0, 1, 1, 1, f); chk("R2/R11 exact location", f, 1'b1);
    txn(3, 10'h20, 0, 0, 1, 1, 1, f); chk("R2 row differs", f, 1'b0);
    txn(2, 10'h21, 0, 0, 1, 1, 1, f); chk("R2 col differs", f, 1'b0);
    txn(2, 10'h20, 1, 0, 1, 1, 1, f); chk("R2 bank differs", f, 1'b0);
    txn(2, 10'h20, 0, 1, 1, 1, 1, f); chk("R2 sub differs", f, 1'b0);
    txn(2, 10'h20, 0, 0, 1, 1, 1, f); chk("R5 persistent repeat", f, 1'b1);
  endtask

  task automatic t_mask;
    logic f;
    cfg(0, 3);
    txn(1, 10'h20, 0, 0, 1, 1, 1, f); chk("R3 masked low row bits", f, 1'b1);
    txn(6, 10'h20, 0, 0, 1, 1, 1, f); chk("R3 unmasked row bit2", f, 1'b0);
    cfg(1, 32'h3ff);
    txn(2, 10'h155, 0, 0, 1, 1, 1, f); chk("R3 col fully masked", f, 1'b1);
    cfg(0, 0); cfg(1, 0);
  endtask

  task automatic t_qualify;
    logic f;
    txn(2, 10'h20, 0, 0, 1, 0, 1, f); chk("R9 valid without ready", f, 1'b0);
    txn(2, 10'h20, 0, 0, 0, 1, 1, f); chk("R9 ready without valid", f, 1'b0);
    txn(2, 10'h20, 0, 0, 1, 1, 0, f); chk("R10 non-write ignored", f, 1'b0);
    cfg(15, 2);
    txn(2, 10'h20, 0, 0, 1, 1, 1, f); chk("R4 enable off", f, 1'b0);
  endtask

  task automatic t_oneshot;
    logic f;
    cfg(15, 1);
    chk("R7 done clear after ctl write", oneshot_done, 1'b0);
    txn(2, 10'h20, 0, 0, 1, 0, 1, f); chk("R9 stall no flag", f, 1'b0);
    txn(2, 10'h20, 0, 0, 1, 1, 1, f); chk("R6 first hit flagged", f, 1'b1);
    chk("R8 done set", oneshot_done, 1'b1);
    txn(2, 10'h20, 0, 0, 1, 1, 1, f); chk("R6 second hit ignored", f, 1'b0);
    chk("R8 done stays", oneshot_done, 1'b1);
    cfg(15, 1);
    chk("R7 done cleared by rearm", oneshot_done, 1'b0);
    txn(2, 10'h20, 0, 0, 1, 1, 1, f); chk("R7 rearmed hit", f, 1'b1);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_exact();
        t_mask();
        t_qualify();
        t_oneshot();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule